// File: doc/BRIEF.md
# Rate-Selectable Parallel-to-Serial Converter

This block takes an 8-bit parallel word and sends it out one bit at a time on a single serial line. It also drives a word clock. The word clock tells the logic upstream where the block is in the word cycle, so that a fresh word is on the parallel inputs when the next capture happens. Words follow each other with no idle bits between them.

A rate select input sets the serial bit rate. When it is low, the block sends one bit per clock. When it is high, it sends one bit every two clocks. The slower rate uses a clock enable inside the single clock domain, not a second clock. A new rate setting only takes effect when a new word is captured, so no word is ever cut short.

The time from capture to the first serial bit is fixed at seven clocks, whichever rate is in use. It is set by a bit delay line of fixed length and does not depend on when reset was released. The word clock is updated only on the falling clock edge.

Top module: `p2s_serializer`

## Requirements
- R1: Within each word, bit 0 of `par_in` is sent first and bit 7 last. Bit i is sent in bit time i.
- R2: With `half_rate` low (full rate), each bit lasts one clock. If a word is captured at rising edge E, its bit 0 is on `ser_out` right after rising edge E+7.
- R3: With `half_rate` high (half rate), each bit lasts two clocks and a word lasts 16 clocks. The capture-to-first-bit latency is still seven clocks.
- R4: The first capture happens at the first rising edge after reset is released. After that, one word is captured every 8 clocks at full rate and every 16 clocks at half rate, so words run back to back with no gap.
- R5: `half_rate` is sampled only at a capture edge. The sampled value sets the rate of the word captured at that edge. Changes at any other time have no effect on the word in progress.
- R6: `word_clk` is high during bit times 0 to 3 of the word being shifted and low during bit times 4 to 7. It rises at the falling edge that follows a capture edge. Before the first capture it is low.
- R7: `word_clk` changes only on falling clock edges. It is stable across every rising edge.
- R8: The synchronous reset `rst` clears the shift state and the delay line. `ser_out` and `word_clk` are then low. `ser_out` stays low until the first captured bit arrives seven clocks after the first capture.
- R9: `par_in` is ignored at every rising edge except capture edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Rising edge for data, falling edge for the word clock |
| rst | input | 1 | Active-high synchronous reset |
| half_rate | input | 1 | 0: one bit per clock, 1: one bit per two clocks. Sampled at capture |
| par_in | input | 8 | Parallel word. Bit 0 is sent first |
| ser_out | output | 1 | Serial data stream |
| word_clk | output | 1 | Word clock, high for the first half of each word |

## Verification
The bench goes after the exact seven-clock latency. A pipeline that is one stage short or one stage long would shift every bit by a clock, and the per-cycle comparison against the reference stream catches that. It also toggles `half_rate` at random on every clock and changes `par_in` on every clock. A design that applied the rate in the middle of a word would produce words with mixed bit lengths. A design that sampled data outside capture edges would mix bits from different words. It checks both that `word_clk` holds across every rising edge and that it has the right level after each falling edge, which catches a clock that runs off the wrong edge or is high for the wrong half of the word. Resets in the middle of the stream check that the output returns to low, and that capture restarts at the first edge after release.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;
endpackage

// File: rtl/p2s_rate_ctrl.sv
module p2s_rate_ctrl
    import p2s_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          half_rate,
    output logic          tick,
    output logic          boundary,
    output logic [CW-1:0] bit_idx
);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        rate_e         rate;
        logic          phase;
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.rate == RATE_HALF) ? st_q.phase : 1'b1;
        boundary = tick && (st_q.cnt == LAST);
        if (boundary) begin
            st_d.rate  = half_rate ? RATE_HALF : RATE_FULL;
            st_d.cnt   = '0;
            st_d.phase = ~half_rate;
        end else begin
            st_d.phase = (st_q.rate == RATE_HALF) ? ~st_q.phase : 1'b1;
            if (tick) st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rate  <= RATE_FULL;
            st_q.phase <= 1'b1;
            st_q.cnt   <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_idx = st_q.cnt;

    // Rate only moves at a capture edge
    assert_rate_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> st_q.rate == $past(st_q.rate));

    // At half rate a bit step is never followed by another in the next clock
    assert_half_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.rate == RATE_HALF && tick && !boundary) |=> !tick);

    // Bit index walks up by one per step inside a word
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !boundary) |=> bit_idx == $past(bit_idx) + CW'(1));
endmodule

// File: rtl/p2s_word_shifter.sv
module p2s_word_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] din,
    output logic             bit_out
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)      st_d.sh = din;
        else if (step) st_d.sh = {1'b0, st_q.sh[WIDTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bit_out = st_q.sh[0];

    // Lowest input bit leaves first after a capture
    assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> bit_out == $past(din[0]));
endmodule

// File: rtl/p2s_bit_delay.sv
module p2s_bit_delay #(
    parameter int LATENCY = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [LATENCY-1:0] line;
    } state_t;

    state_t st_d, st_q;

    generate
        if (LATENCY == 1) begin : g_single
            always_comb st_d.line = din;
        end else begin : g_chain
            always_comb st_d.line = {st_q.line[LATENCY-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.line[LATENCY-1];
endmodule

// File: rtl/p2s_word_clock.sv
module p2s_word_clock #(
    parameter int WIDTH = 8,
    localparam int CW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] bit_idx,
    output logic          word_clk
);
    localparam logic [CW-1:0] HALF = CW'(WIDTH / 2);

    logic wclk_d, wclk_q;

    always_comb wclk_d = (bit_idx < HALF);

    always_ff @(negedge clk) begin
        if (rst) wclk_q <= 1'b0;
        else     wclk_q <= wclk_d;
    end

    assign word_clk = wclk_q;
endmodule

// File: rtl/p2s_serializer.sv
module p2s_serializer
    import p2s_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int LATENCY = 7,
    localparam int CW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_rate,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out,
    output logic             word_clk
);
    logic          tick, boundary, raw_bit;
    logic [CW-1:0] bit_idx;

    p2s_rate_ctrl #(.WIDTH(WIDTH)) u_rate (
        .clk(clk), .rst(rst), .half_rate(half_rate),
        .tick(tick), .boundary(boundary), .bit_idx(bit_idx)
    );

    p2s_word_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst(rst), .load(boundary), .step(tick),
        .din(par_in), .bit_out(raw_bit)
    );

    p2s_bit_delay #(.LATENCY(LATENCY)) u_delay (
        .clk(clk), .rst(rst), .din(raw_bit), .dout(ser_out)
    );

    p2s_word_clock #(.WIDTH(WIDTH)) u_wclk (
        .clk(clk), .rst(rst), .bit_idx(bit_idx), .word_clk(word_clk)
    );

    // Output is quiet on the cycle after a reset edge
    assert_quiet_after_reset_R8: assert property (@(posedge clk)
        $past(rst) |-> !ser_out);
endmodule

// File: tb/tb_p2s_serializer.sv
module tb_p2s_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_rate = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       ser_out, word_clk;

    always #2 clk = ~clk;

    p2s_serializer dut (
        .clk(clk), .rst(rst), .half_rate(half_rate), .par_in(par_in),
        .ser_out(ser_out), .word_clk(word_clk)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit q[$];
    bit pre;
    int pos;
    int mult;
    bit in_rst;
    bit started = 1'b0;
    bit exp_sout, exp_wclk;

    task automatic check(input bit ok, input string tag, input logic act, input bit exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            q.delete();
            for (int i = 0; i < 7; i++) q.push_back(1'b0);
            pre = 1'b1; pos = 0; mult = 1; in_rst = 1'b1;
            exp_sout = 1'b0; exp_wclk = 1'b0;
        end else begin
            in_rst = 1'b0;
            if (pre || pos == 8 * mult - 1) begin
                mult = half_rate ? 2 : 1;
                pre = 1'b0; pos = 0;
                for (int b = 0; b < 8; b++)
                    for (int r = 0; r < mult; r++) q.push_back(par_in[b]);
            end else begin
                pos++;
            end
            exp_sout = q.pop_front();
            exp_wclk = pre ? 1'b0 : ((pos / mult) < 4);
        end
    endtask

    task automatic cycle(input logic nrst, input logic nsel, input logic [7:0] nd);
        bit prev_wclk;
        string tag;
        prev_wclk = exp_wclk;
        @(posedge clk);
        model_step();
        #1;
        if (started) check(word_clk === prev_wclk, "R7 word clock moved at rising edge", word_clk, prev_wclk);
        rst = nrst; half_rate = nsel; par_in = nd;
        #2;
        if (in_rst)        tag = "R8 reset output";
        else if (mult == 2) tag = "R3 R5 R1 half-rate stream";
        else               tag = "R1 R2 R4 R9 full-rate stream";
        check(ser_out === exp_sout, tag, ser_out, exp_sout);
        check(word_clk === exp_wclk, in_rst ? "R8 word clock in reset" : "R6 word clock level",
              word_clk, exp_wclk);
        started = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_wclk = 1'b0;
        repeat (3) cycle(1'b1, 1'b0, 8'h00);
        // full rate: first capture follows release at once (R4, R2)
        cycle(1'b0, 1'b0, 8'h01);
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 8'h01);
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 8'h80);
        for (int i = 0; i < 24; i++) cycle(1'b0, 1'b0, 8'hFF);
        for (int i = 0; i < 24; i++) cycle(1'b0, 1'b0, 8'h00);
        // random data every clock: only capture edges matter (R9)
        for (int i = 0; i < 200; i++) cycle(1'b0, 1'b0, 8'($urandom));
        // half rate (R3)
        for (int i = 0; i < 300; i++) cycle(1'b0, 1'b1, 8'($urandom));
        // rate select toggling every clock (R5)
        for (int i = 0; i < 800; i++) cycle(1'b0, 1'($urandom), 8'($urandom));
        // reset mid-stream, then restart in half rate (R8)
        cycle(1'b1, 1'b1, 8'hA5);
        cycle(1'b1, 1'b1, 8'hA5);
        cycle(1'b0, 1'b1, 8'h3C);
        for (int i = 0; i < 200; i++) cycle(1'b0, 1'b1, 8'($urandom));
        // reset again, restart in full rate
        cycle(1'b1, 1'b0, 8'h00);
        cycle(1'b0, 1'b0, 8'hC3);
        for (int i = 0; i < 200; i++) cycle(1'b0, 1'($urandom), 8'($urandom));
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule